// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers interrupt requests from a parameterized set of sources and presents at most one of them to the processor at a time. Each source has a pending flag, an enable bit and a 4-bit priority. The priority is read from a priority register that is selected per source through a fixed map, so a group of neighbouring sources shares one register. The outstanding request is driven as a 12-bit word: the priority in the upper four bits and the source number in the lower eight. A word of zero means that no request is outstanding.

The processor retires the outstanding request with a one-cycle acknowledge. The block then arbitrates again among the enabled pending sources. A source is either edge-type or level-sensitive. Edge-type sources receive one-cycle set pulses from an external edge detector. The pending flag of a level-sensitive source follows its input. One programmable vector can be diverted to a separate fast-interrupt output. A byte-wide register port holds the enables, the priorities and the fast-vector register, and it also carries a software-interrupt trigger.

Register addresses: enable byte k sits at 0x000+k, priority register j at 0x100+j, the software-interrupt trigger at 0x200, and the fast-vector register at 0x202.

Top module: `irq_prio_arbiter`

## Requirements
- R1: The enable for source n is bit (n mod 8) of the enable byte at address n/8. A pending source whose enable is 0 is never requested, and it is requested once its enable is set.
- R2: The priority of source n is bits 3:0 of the priority register at 0x100 + n/2. A pending source with priority 0 is never requested. Source 0 is never requested, whatever its priority.
- R3: A request word is {priority[3:0], source[7:0]}, and zero means no request. With the slot empty, an edge pulse sampled at one clock edge shows up as a request at the next edge. When several sources arrive together, the highest priority wins.
- R4: While a request is outstanding it stays unchanged, even when a source with a higher priority becomes pending. Only an acknowledge or the release of a level-sensitive owner removes it.
- R5: An acknowledge empties the slot at that edge, so the output reads zero, and it clears the pending flag of an edge-type owner. At the next edge the enabled pending source with the highest nonzero priority is requested. On a tie, the lowest source number wins.
- R6: Sources set in LEVEL_MASK (default 4 to 7) are level-sensitive, and their pending flag follows the input one edge late. An acknowledged level source whose input is still high is requested again. When a level owner's input falls, the request drops to zero at the second edge after the fall.
- R7: In the 16-bit fast register, bit 15 is the enable and bits 7:0 are the vector. When it is enabled and the outstanding source matches the vector, the word appears on fiq_req and irq_req is zero. Otherwise the word appears on irq_req. The two outputs are never both nonzero.
- R8: The fast register accepts only 16-bit accesses and every other address only byte accesses. A wrong-size write changes nothing, and a wrong-size read returns 0xFFFF.
- R9: A byte write with bit 0 set to address 0x200 gives swi_pulse high for exactly the cycle after the write edge. That address reads zero.
- R10: After reset all enables, priorities and the fast register are zero, no request is outstanding, and swi_pulse is low.
- R11: Enable bytes read back all 8 bits. Priority registers read back bits 3:0, with the upper bits zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Edge set pulses or level inputs, one per source |
| ack | input | 1 | One-cycle acknowledge of the outstanding request |
| cfg_addr | input | 10 | Register address |
| cfg_wr | input | 1 | Write strobe |
| cfg_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr and cfg_wide |
| irq_req | output | 12 | Normal request word |
| fiq_req | output | 12 | Fast request word |
| swi_pulse | output | 1 | Software-interrupt pulse |

## Verification
The main function is driven by sets of simultaneous edge pulses. These include single sources, equal-priority pairs that expose the tie rule, mixes where a shared priority register makes neighbours equal, and sets that contain disabled, zero-priority or source-0 members. The count of acknowledges needed to drain each set separates correct re-arbitration from a lost or a duplicated pending flag. Directed sequences show that a held slot ignores a later higher-priority arrival, and that a level source is re-requested until its input falls. They also show that the fast vector moves the word between the two outputs, and that a late enable releases a source that was waiting.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants and the request word layout for the arbiter.
// Assumes a 10-bit register address space and 4-bit priorities.
package irq_arb_pkg;
    localparam int PRI_W  = 4;
    localparam int VEC_W  = 8;
    localparam int REQ_W  = PRI_W + VEC_W;
    localparam int CFG_AW = 10;
    localparam int CFG_DW = 16;

    localparam logic [CFG_AW-1:0] ENA_BASE  = 10'h000;
    localparam logic [CFG_AW-1:0] PRI_BASE  = 10'h100;
    localparam logic [CFG_AW-1:0] SWI_ADDR  = 10'h200;
    localparam logic [CFG_AW-1:0] FAST_ADDR = 10'h202;

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } req_word_t;
endpackage

// File: rtl/irq_arb_regs.sv
// Module: register file for the enables, the priorities, the fast vector and the
// software trigger. Reads are combinational. Access size is checked per address:
// only the fast register takes 16-bit accesses.
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_PRI = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic                           cfg_wr,
    input  logic                           cfg_wide,
    input  logic [CFG_DW-1:0]              cfg_wdata,
    output logic [CFG_DW-1:0]              cfg_rdata,
    output logic [NUM_SRC-1:0]             ena,
    output logic [NUM_PRI-1:0][PRI_W-1:0]  pri_tab,
    output logic                           fast_en,
    output logic [VEC_W-1:0]               fast_vec,
    output logic                           swi_pulse
);
    localparam int ENA_BYTES = (NUM_SRC + 7) / 8;

    logic [ENA_BYTES*8-1:0]          ena_q;
    logic [NUM_PRI-1:0][PRI_W-1:0]   pri_q;
    logic                            is_fast;
    logic                            size_ok;
    logic                            wr_ok;
    logic                            unused_wdata;

    assign is_fast      = (cfg_addr == FAST_ADDR);
    assign size_ok      = is_fast ? cfg_wide : !cfg_wide;
    assign wr_ok        = cfg_wr && size_ok;
    assign unused_wdata = ^cfg_wdata[14:8];

    // Purpose: hold the enable bytes, the priority registers and the fast register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q    <= '0;
            pri_q    <= '0;
            fast_en  <= 1'b0;
            fast_vec <= '0;
        end else begin
            for (int k = 0; k < ENA_BYTES; k++) begin
                if (wr_ok && cfg_addr == ENA_BASE + CFG_AW'(k)) begin
                    ena_q[k*8 +: 8] <= cfg_wdata[7:0];
                end
            end
            for (int j = 0; j < NUM_PRI; j++) begin
                if (wr_ok && cfg_addr == PRI_BASE + CFG_AW'(j)) begin
                    pri_q[j] <= cfg_wdata[PRI_W-1:0];
                end
            end
            if (wr_ok && is_fast) begin
                fast_en  <= cfg_wdata[15];
                fast_vec <= cfg_wdata[VEC_W-1:0];
            end
        end
    end

    // Purpose: raise a one-cycle software pulse after a valid trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swi_pulse <= 1'b0;
        end else begin
            swi_pulse <= wr_ok && (cfg_addr == SWI_ADDR) && cfg_wdata[0];
        end
    end

    // Purpose: select read data. A wrong-size access reads all ones.
    always_comb begin
        cfg_rdata = '0;
        if (!size_ok) begin
            cfg_rdata = '1;
        end else if (is_fast) begin
            cfg_rdata = {fast_en, 7'b0, fast_vec};
        end else begin
            for (int k = 0; k < ENA_BYTES; k++) begin
                if (cfg_addr == ENA_BASE + CFG_AW'(k)) begin
                    cfg_rdata = {8'h00, ena_q[k*8 +: 8]};
                end
            end
            for (int j = 0; j < NUM_PRI; j++) begin
                if (cfg_addr == PRI_BASE + CFG_AW'(j)) begin
                    cfg_rdata = {{(CFG_DW-PRI_W){1'b0}}, pri_q[j]};
                end
            end
        end
    end

    assign ena     = ena_q[NUM_SRC-1:0];
    assign pri_tab = pri_q;
endmodule

// File: rtl/irq_arb_pend.sv
// Module: per-source pending flags. Level sources copy their input every cycle.
// Edge sources are set by a one-cycle pulse and cleared by an acknowledge of
// that source. A set wins over a clear in the same cycle.
module irq_arb_pend #(
    parameter int                 NUM_SRC    = 32,
    parameter int                 IDX_W      = 5,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               ack_fire,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] pend
);
    // Purpose: update each pending flag according to its trigger type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (LEVEL_MASK[i]) begin
                    pend[i] <= src_in[i];
                end else if (src_in[i]) begin
                    pend[i] <= 1'b1;
                end else if (ack_fire && ack_idx == IDX_W'(i)) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/irq_arb_pick.sv
// Module: combinational winner selection. Picks the candidate with the highest
// nonzero priority, preferring the lowest index on a tie. Index 0 is skipped.
module irq_arb_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0]             cand,
    input  logic [NUM_SRC-1:0][PRI_W-1:0]  src_pri,
    output logic                           win_vld,
    output logic [IDX_W-1:0]               win_idx,
    output logic [PRI_W-1:0]               win_pri
);
    // Purpose: scan upward. Only a strictly greater priority replaces the best so far.
    always_comb begin
        win_pri = '0;
        win_idx = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (cand[i] && src_pri[i] > win_pri) begin
                win_pri = src_pri[i];
                win_idx = IDX_W'(i);
            end
        end
        win_vld = (win_pri != '0);
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: top of the arbiter. Holds one request slot and loads it from the
// winner whenever the slot is empty. The slot is emptied by an acknowledge or
// when a level owner releases its input. Assumes NUM_SRC <= 256 and that edge
// detection of the raw lines happens outside the block.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int                 NUM_SRC    = 32,
    parameter int                 MAP_SHARE  = 2,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'(8'hF0)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               ack,
    input  logic [9:0]         cfg_addr,
    input  logic               cfg_wr,
    input  logic               cfg_wide,
    input  logic [15:0]        cfg_wdata,
    output logic [15:0]        cfg_rdata,
    output logic [11:0]        irq_req,
    output logic [11:0]        fiq_req,
    output logic               swi_pulse
);
    localparam int NUM_PRI = (NUM_SRC + MAP_SHARE - 1) / MAP_SHARE;
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]             ena;
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_PRI-1:0][PRI_W-1:0]  pri_tab;
    logic [NUM_SRC-1:0][PRI_W-1:0]  src_pri;
    logic                           fast_en;
    logic [VEC_W-1:0]               fast_vec;
    logic                           win_vld;
    logic [IDX_W-1:0]               win_idx;
    logic [PRI_W-1:0]               win_pri;
    logic                           slot_vld;
    logic [IDX_W-1:0]               slot_idx;
    logic [PRI_W-1:0]               slot_pri;
    logic                           lvl_drop;
    logic                           fast_hit;
    req_word_t                      word;

    irq_arb_regs #(.NUM_SRC(NUM_SRC), .NUM_PRI(NUM_PRI)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wide(cfg_wide),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ena(ena), .pri_tab(pri_tab),
        .fast_en(fast_en), .fast_vec(fast_vec), .swi_pulse(swi_pulse)
    );

    irq_arb_pend #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .LEVEL_MASK(LEVEL_MASK)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .ack_fire(ack && slot_vld), .ack_idx(slot_idx), .pend(pend)
    );

    // Each source reads its priority from the register that the map assigns to it.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
        localparam int REG_SEL = g / MAP_SHARE;
        assign src_pri[g] = pri_tab[REG_SEL];
    end

    irq_arb_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .cand(pend & ena), .src_pri(src_pri),
        .win_vld(win_vld), .win_idx(win_idx), .win_pri(win_pri)
    );

    assign lvl_drop = slot_vld && LEVEL_MASK[slot_idx] && !pend[slot_idx];

    // Purpose: single outstanding slot. It is emptied by ack or a level release
    // and loaded only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= 1'b0;
            slot_idx <= '0;
            slot_pri <= '0;
        end else if (slot_vld && (ack || lvl_drop)) begin
            slot_vld <= 1'b0;
        end else if (!slot_vld && win_vld) begin
            slot_vld <= 1'b1;
            slot_idx <= win_idx;
            slot_pri <= win_pri;
        end
    end

    assign word.pri = slot_pri;
    assign word.vec = VEC_W'(slot_idx);
    assign fast_hit = fast_en && (fast_vec == word.vec);
    assign irq_req  = (slot_vld && !fast_hit) ? word : '0;
    assign fiq_req  = (slot_vld &&  fast_hit) ? word : '0;
endmodule

// File: rtl/irq_arb_chk.sv
// Module: property checker bound to the arbiter top. It observes the ports and
// the fast register only.
module irq_arb_chk #(
    parameter int                 NUM_SRC    = 32,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic [9:0]  cfg_addr,
    input logic        cfg_wr,
    input logic        cfg_wide,
    input logic [15:0] cfg_wdata,
    input logic [11:0] irq_req,
    input logic [11:0] fiq_req,
    input logic        swi_pulse,
    input logic        fast_en,
    input logic [7:0]  fast_vec
);
    logic [11:0] out_w;
    logic        own_lvl;

    assign out_w   = irq_req | fiq_req;
    assign own_lvl = |(LEVEL_MASK & (NUM_SRC'(1) << out_w[7:0]));

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (irq_req == 12'h0 && fiq_req == 12'h0 && !swi_pulse)); // R10
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n) !(irq_req != 12'h0 && fiq_req != 12'h0)); // R7
    AST_FAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (fiq_req != 12'h0) |-> (fast_en && fiq_req[7:0] == fast_vec)); // R7
    AST_NONZERO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (out_w != 12'h0) |-> (out_w[11:8] != 4'h0 && out_w[7:0] != 8'h0)); // R2
    AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (out_w != 12'h0 && !ack && !own_lvl) |=> (out_w == $past(out_w))); // R4
    AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (ack && out_w != 12'h0) |=> (out_w == 12'h0)); // R5
    AST_SWI_PULSE: assert property (@(posedge clk) disable iff (!rst_n) swi_pulse == $past(cfg_wr && !cfg_wide && cfg_addr == 10'h200 && cfg_wdata[0])); // R9
endmodule

bind irq_prio_arbiter irq_arb_chk #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wide(cfg_wide), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .fiq_req(fiq_req), .swi_pulse(swi_pulse),
    .fast_en(fast_en), .fast_vec(fast_vec)
);

// File: tb/sim_irq_prio_arbiter.sv
`timescale 1ns/1ps
module sim_irq_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        ack = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [11:0] irq_req;
    logic [11:0] fiq_req;
    logic        swi_pulse;
    logic [31:0] lvl_hold = '0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    irq_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .ack(ack),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wide(cfg_wide),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_req(irq_req), .fiq_req(fiq_req), .swi_pulse(swi_pulse)
    );

    // {pulse mask, expected first request, acknowledges needed to drain}
    // Priorities: source s uses register s/2, which holds (s/2*5)%16, and register 12 holds 0.
    localparam logic [51:0] VECS [10] = '{
        {32'h0000_0004, 12'h502, 8'd1},
        {32'h0000_000C, 12'h502, 8'd2},
        {32'h0000_0500, 12'h90A, 8'd2},
        {32'h0000_1000, 12'h000, 8'd0},
        {32'h0100_0000, 12'h000, 8'd0},
        {32'h0000_0001, 12'h000, 8'd0},
        {32'hC000_0008, 12'hB1E, 8'd3},
        {32'h0005_0000, 12'hD12, 8'd2},
        {32'h3010_0000, 12'h61C, 8'd3},
        {32'h0402_0A00, 12'h90B, 8'd4}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [9:0] a, input logic [15:0] d, input logic w);
        cfg_addr = a; cfg_wdata = d; cfg_wide = w; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wide = 1'b0;
    endtask

    task automatic cfg_read(input logic [9:0] a, input logic w, output logic [15:0] d);
        cfg_addr = a; cfg_wide = w;
        #1 d = cfg_rdata;
        cfg_wide = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] m);
        src_in = m | lvl_hold;
        @(negedge clk);
        src_in = lvl_hold;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while ((irq_req | fiq_req) != 12'h0 && n < 64) begin
            do_ack();
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 irq_req", {4'h0, irq_req}, 16'h0);
        chk("R10 fiq_req", {4'h0, fiq_req}, 16'h0);
        chk("R10 swi", {15'h0, swi_pulse}, 16'h0);
        cfg_read(10'h000, 1'b0, rd); chk("R10 enable byte", rd, 16'h0000);
        cfg_read(10'h202, 1'b1, rd); chk("R10 fast reg", rd, 16'h0000);

        // setup: enables (byte1 only low half) and priorities
        for (int k = 0; k < 4; k++) cfg_write(10'(k), (k == 1) ? 16'h000F : 16'h00FF, 1'b0);
        for (int j = 0; j < 16; j++) cfg_write(10'h100 + 10'(j), (j == 12) ? 16'h0 : 16'((j * 5) % 16), 1'b0);

        // table of simultaneous pulse sets
        for (int t = 0; t < 10; t++) begin
            logic [31:0] m; logic [11:0] e; logic [7:0] c;
            {m, e, c} = VECS[t];
            pulse(m);
            @(negedge clk);
            chk($sformatf("R3 first request entry %0d", t), {4'h0, irq_req | fiq_req}, {4'h0, e});
            drain(n);
            chk($sformatf("R5 drain count entry %0d", t), 16'(n), {8'h0, c});
        end

        // R1: source 12 waited while disabled, enabling it releases it
        cfg_write(10'h001, 16'h00FF, 1'b0);
        @(negedge clk);
        chk("R1 late enable", {4'h0, irq_req}, 16'h0E0C);
        drain(n); chk("R1 drain", 16'(n), 16'd1);

        // R2: source 0 is never requested, a zero-priority source waits
        cfg_write(10'h100, 16'h0009, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R2 source 0 ignored", {4'h0, irq_req}, 16'h0000);
        cfg_write(10'h10C, 16'h0002, 1'b0);
        @(negedge clk);
        chk("R2 priority raised", {4'h0, irq_req}, 16'h0218);
        drain(n); chk("R2 drain", 16'(n), 16'd1);

        // R4: higher-priority arrival does not displace the held request
        pulse(32'h0000_0100);
        @(negedge clk);
        chk("R4 first", {4'h0, irq_req}, 16'h0408);
        pulse(32'h4000_0000);
        @(negedge clk);
        chk("R4 held", {4'h0, irq_req}, 16'h0408);
        do_ack();
        chk("R5 empty after ack", {4'h0, irq_req}, 16'h0000);
        @(negedge clk);
        chk("R5 next winner", {4'h0, irq_req}, 16'h0B1E);
        drain(n); chk("R4 drain", 16'(n), 16'd1);

        // R6: level source 6
        lvl_hold = 32'h0000_0040; src_in = lvl_hold;
        @(negedge clk); @(negedge clk);
        chk("R6 level request", {4'h0, irq_req}, 16'h0F06);
        do_ack();
        chk("R6 empty after ack", {4'h0, irq_req}, 16'h0000);
        @(negedge clk);
        chk("R6 re-requested", {4'h0, irq_req}, 16'h0F06);
        lvl_hold = '0; src_in = '0;
        @(negedge clk);
        chk("R6 still held one edge", {4'h0, irq_req}, 16'h0F06);
        @(negedge clk);
        chk("R6 released", {4'h0, irq_req}, 16'h0000);

        // R7: fast routing of vector 10
        cfg_write(10'h202, 16'h800A, 1'b1);
        cfg_read(10'h202, 1'b1, rd); chk("R7 fast readback", rd, 16'h800A);
        pulse(32'h0000_0400);
        @(negedge clk);
        chk("R7 fast line", {4'h0, fiq_req}, 16'h090A);
        chk("R7 normal quiet", {4'h0, irq_req}, 16'h0000);
        drain(n);
        pulse(32'h0000_0800);
        @(negedge clk);
        chk("R7 other vector normal", {4'h0, irq_req}, 16'h090B);
        chk("R7 other vector fast quiet", {4'h0, fiq_req}, 16'h0000);
        drain(n);
        cfg_write(10'h202, 16'h0000, 1'b1);

        // R8: access size rules
        cfg_read(10'h202, 1'b0, rd); chk("R8 byte read fast", rd, 16'hFFFF);
        cfg_read(10'h000, 1'b1, rd); chk("R8 wide read enable", rd, 16'hFFFF);
        cfg_write(10'h002, 16'h0000, 1'b1);
        cfg_read(10'h002, 1'b0, rd); chk("R8 wide write ignored", rd, 16'h00FF);
        cfg_write(10'h202, 16'h8001, 1'b0);
        cfg_read(10'h202, 1'b1, rd); chk("R8 byte write fast ignored", rd, 16'h0000);

        // R9: software pulse
        cfg_write(10'h200, 16'h0001, 1'b0);
        chk("R9 pulse high", {15'h0, swi_pulse}, 16'h0001);
        @(negedge clk);
        chk("R9 pulse one cycle", {15'h0, swi_pulse}, 16'h0000);
        cfg_write(10'h200, 16'h0002, 1'b0);
        chk("R9 bit0 clear no pulse", {15'h0, swi_pulse}, 16'h0000);
        cfg_read(10'h200, 1'b0, rd); chk("R9 reads zero", rd, 16'h0000);

        // R11: readback widths
        cfg_read(10'h001, 1'b0, rd); chk("R11 enable byte", rd, 16'h00FF);
        cfg_write(10'h101, 16'h00F5, 1'b0);
        cfg_read(10'h101, 1'b0, rd); chk("R11 priority 4 bits", rd, 16'h0005);
        cfg_read(10'h3FF, 1'b0, rd); chk("R11 unmapped", rd, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule